// File: doc/BRIEF.md
# Frame-Slotted Monitor Byte Channel Controller

This block runs the monitor byte channel of a serial bus that is divided into frames, with each frame split into two subframes. A frame-sync pulse and a bit-rate enable tell the block where the bit periods are. It counts bit periods from the sync to find the monitor octet of the chosen subframe. In that octet it shifts out one transmit byte, most significant bit first, and shifts in one receive byte.

Software drives the block through a few inputs:
- level inputs for enable, subframe select and abort;
- set and clear strobes for an end-of-message request;
- a write strobe that loads the transmit data register.

Each transmitted octet also carries a 2-bit kind code that marks it as idle, data, end-of-message or abort. When the channel is disabled, both data registers are forced to fixed defaults.

Top module: `mon_chan_ctrl`

## Requirements
- R1: While `cfg_enable` is low, `tx_oe` stays low, `tx_bit` stays 1, `tx_kind` stays 0 and `rx_stb` never pulses. Writes through `wr_en` leave `tx_reg` at 0xFF and `tx_pending` low.
- R2: After reset, and in every cycle that follows a cycle with `cfg_enable` low, `tx_reg` reads 0xFF and `rx_data` reads 0x00.
- R3: Bit period 0 of a frame is the period that begins at the bit-enable edge where `fsync` is high. With the default parameters, the monitor octet occupies bit periods 8 to 15 when `cfg_sel` is 0 and bit periods 40 to 47 when `cfg_sel` is 1. Bits travel most significant bit first, and `tx_oe` is high only in that octet.
- R4: A write sets `tx_pending`. The written byte goes out in the next selected octet with kind 1 (data), and `tx_pending` clears when that octet starts.
- R5: While `eom_pend` is set, an end-of-message octet (kind 2, data 0xFF) goes out only in an octet where no write is pending. Any pending byte is sent first.
- R6: `eom_set` raises `eom_pend`. The block clears `eom_pend` when the end-of-message octet starts, and software can clear it with `eom_clr` (clear wins over set).
- R7: While `cfg_abort` is high, every selected octet carries kind 3 (abort) with data 0xFF, and a pending byte is discarded (`tx_pending` clears). Kind 3 is sent in every frame for as long as the level is held.
- R8: With nothing pending, no end-of-message request and no abort, the selected octet carries kind 0 (idle) and data 0xFF.
- R9: The byte received in the selected octet is loaded into `rx_data` at the bit-enable edge that ends the octet. `rx_stb` is high for exactly the following clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle enable that marks a bit-period boundary |
| fsync | input | 1 | Frame sync, qualified by `bit_en` |
| rx_bit | input | 1 | Serial receive data |
| cfg_enable | input | 1 | Channel enable |
| cfg_sel | input | 1 | Subframe select (0 first, 1 second) |
| cfg_abort | input | 1 | Abort request level |
| eom_set | input | 1 | Set end-of-message request |
| eom_clr | input | 1 | Clear end-of-message request |
| wr_en | input | 1 | Transmit register write strobe |
| wr_data | input | 8 | Transmit register write data |
| tx_bit | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Transmit drive enable |
| tx_kind | output | 2 | Octet kind: 0 idle, 1 data, 2 end-of-message, 3 abort |
| tx_reg | output | 8 | Transmit data register |
| tx_pending | output | 1 | A written byte is waiting to be sent |
| eom_pend | output | 1 | End-of-message request outstanding |
| rx_data | output | 8 | Receive data register |
| rx_stb | output | 1 | One-cycle byte-received strobe |

## Verification
The assertions assume three things about the inputs:
- `fsync` is only high together with `bit_en`, and frames are exactly 64 bit periods long.
- `cfg_sel` does not change while a frame is in progress.
- Software strobes are never asserted in a cycle that also has `bit_en` high.

The bench keeps within these limits. It gives every bit period a bit-enable cycle followed by a quiet cycle, and it changes configuration and issues writes only in extra quiet cycles between whole frames.

// File: rtl/mon_pkg.sv
package mon_pkg;
  typedef enum logic [1:0] {
    KIND_IDLE  = 2'd0,
    KIND_DATA  = 2'd1,
    KIND_EOM   = 2'd2,
    KIND_ABORT = 2'd3
  } mon_kind_e;
endpackage

// File: rtl/mon_slot_timer.sv
module mon_slot_timer #(
  parameter int OCT_PER_SUB = 4,
  parameter int MON_OFS     = 1,
  parameter int SUBFRAMES   = 2
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        bit_en,
  input  logic                                        fsync,
  input  logic                                        sel,
  output logic                                        enter_slot,
  output logic                                        in_slot,
  output logic                                        slot_last,
  output logic [2:0]                                  bit_idx
);
  localparam int FRAME_BITS = 8 * OCT_PER_SUB * SUBFRAMES;
  localparam int CW         = $clog2(FRAME_BITS);
  localparam int START0     = MON_OFS * 8;
  localparam int START1     = (OCT_PER_SUB + MON_OFS) * 8;

  logic [CW-1:0] cnt_q, cnt_n, start;
  logic          sync_q, sync_n;
  logic [CW-1:0] offs;

  assign start = sel ? CW'(START1) : CW'(START0);

  always_comb begin
    cnt_n  = cnt_q;
    sync_n = sync_q;
    if (bit_en) begin
      if (fsync) begin
        cnt_n  = '0;
        sync_n = 1'b1;
      end else if (cnt_q == CW'(FRAME_BITS - 1)) begin
        cnt_n = '0;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sync_q <= 1'b0;
    end else if (bit_en) begin
      cnt_q  <= cnt_n;
      sync_q <= sync_n;
    end
  end

  assign offs       = cnt_q - start;
  assign in_slot    = sync_q && (cnt_q >= start) && (cnt_q <= start + CW'(7));
  assign bit_idx    = offs[2:0];
  assign slot_last  = in_slot && (bit_idx == 3'd7);
  assign enter_slot = bit_en && sync_n && (cnt_n == start);

  assert_fsync_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && fsync) |=> (cnt_q == '0) && sync_q);
  assert_frame_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !fsync && sync_q && cnt_q == CW'(FRAME_BITS - 1)) |=> (cnt_q == '0));
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(cnt_q));
endmodule

// File: rtl/mon_tx.sv
module mon_tx
  import mon_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       abort,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       eom_set,
  input  logic       eom_clr,
  input  logic       enter_slot,
  input  logic       in_slot,
  input  logic [2:0] bit_idx,
  output logic       tx_bit,
  output logic       tx_oe,
  output logic [1:0] tx_kind,
  output logic [7:0] tx_reg,
  output logic       tx_pending,
  output logic       eom_pend
);
  logic [7:0] txd_q, txd_n, obyte_q, obyte_n;
  logic       pend_q, pend_n, eom_q, eom_n;
  mon_kind_e  kind_q, kind_n;

  always_comb begin
    txd_n   = txd_q;
    pend_n  = pend_q;
    eom_n   = eom_q;
    obyte_n = obyte_q;
    kind_n  = kind_q;
    if (eom_clr)      eom_n = 1'b0;
    else if (eom_set) eom_n = 1'b1;
    if (!en) begin
      txd_n   = 8'hFF;
      pend_n  = 1'b0;
      obyte_n = 8'hFF;
      kind_n  = KIND_IDLE;
    end else begin
      if (enter_slot) begin
        obyte_n = 8'hFF;
        if (abort) begin
          kind_n = KIND_ABORT;
          pend_n = 1'b0;
        end else if (pend_q) begin
          kind_n  = KIND_DATA;
          obyte_n = txd_q;
          pend_n  = 1'b0;
        end else if (eom_q) begin
          kind_n = KIND_EOM;
          eom_n  = 1'b0;
        end else begin
          kind_n = KIND_IDLE;
        end
      end
      if (wr_en) begin
        txd_n  = wr_data;
        pend_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q   <= 8'hFF;
      pend_q  <= 1'b0;
      eom_q   <= 1'b0;
      obyte_q <= 8'hFF;
      kind_q  <= KIND_IDLE;
    end else begin
      txd_q   <= txd_n;
      pend_q  <= pend_n;
      eom_q   <= eom_n;
      obyte_q <= obyte_n;
      kind_q  <= kind_n;
    end
  end

  assign tx_oe      = en && in_slot;
  assign tx_bit     = tx_oe ? obyte_q[3'd7 - bit_idx] : 1'b1;
  assign tx_kind    = tx_oe ? kind_q : KIND_IDLE;
  assign tx_reg     = txd_q;
  assign tx_pending = pend_q;
  assign eom_pend   = eom_q;

  assert_data_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && enter_slot && !abort && pend_q) |=> (kind_q == KIND_DATA) && (obyte_q == $past(txd_q)));
  assert_eom_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && enter_slot && !abort && !pend_q && eom_q && !eom_clr) |=> (kind_q == KIND_EOM) && !eom_q);
  assert_abort_discard_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && enter_slot && abort && !wr_en) |=> (kind_q == KIND_ABORT) && !pend_q);
  assert_off_default_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (txd_q == 8'hFF) && !pend_q);
endmodule

// File: rtl/mon_rx.sv
module mon_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       bit_en,
  input  logic       in_slot,
  input  logic       slot_last,
  input  logic       rx_bit,
  output logic [7:0] rx_data,
  output logic       rx_stb
);
  logic [6:0] sh_q, sh_n;
  logic [7:0] rxd_q, rxd_n;
  logic       stb_q, stb_n;

  always_comb begin
    sh_n  = sh_q;
    rxd_n = rxd_q;
    stb_n = 1'b0;
    if (!en) begin
      rxd_n = 8'h00;
    end else if (bit_en && in_slot) begin
      sh_n = {sh_q[5:0], rx_bit};
      if (slot_last) begin
        rxd_n = {sh_q, rx_bit};
        stb_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      rxd_q <= 8'h00;
      stb_q <= 1'b0;
    end else begin
      sh_q  <= sh_n;
      rxd_q <= rxd_n;
      stb_q <= stb_n;
    end
  end

  assign rx_data = rxd_q;
  assign rx_stb  = stb_q;

  assert_stb_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stb |=> !rx_stb);
  assert_rx_default_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (rx_data == 8'h00) && !rx_stb);
  assert_stable_between_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !(bit_en && slot_last)) |=> $stable(rx_data));
endmodule

// File: rtl/mon_chan_ctrl.sv
module mon_chan_ctrl #(
  parameter int OCT_PER_SUB = 4,
  parameter int MON_OFS     = 1,
  parameter int SUBFRAMES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       fsync,
  input  logic       rx_bit,
  input  logic       cfg_enable,
  input  logic       cfg_sel,
  input  logic       cfg_abort,
  input  logic       eom_set,
  input  logic       eom_clr,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       tx_bit,
  output logic       tx_oe,
  output logic [1:0] tx_kind,
  output logic [7:0] tx_reg,
  output logic       tx_pending,
  output logic       eom_pend,
  output logic [7:0] rx_data,
  output logic       rx_stb
);
  logic [1:0] rs_q;
  logic       rst_i_n;
  logic       enter_slot, in_slot, slot_last;
  logic [2:0] bit_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  mon_slot_timer #(
    .OCT_PER_SUB (OCT_PER_SUB),
    .MON_OFS     (MON_OFS),
    .SUBFRAMES   (SUBFRAMES)
  ) u_tim (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .bit_en     (bit_en),
    .fsync      (fsync),
    .sel        (cfg_sel),
    .enter_slot (enter_slot),
    .in_slot    (in_slot),
    .slot_last  (slot_last),
    .bit_idx    (bit_idx)
  );

  mon_tx u_tx (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .en         (cfg_enable),
    .abort      (cfg_abort),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .eom_set    (eom_set),
    .eom_clr    (eom_clr),
    .enter_slot (enter_slot),
    .in_slot    (in_slot),
    .bit_idx    (bit_idx),
    .tx_bit     (tx_bit),
    .tx_oe      (tx_oe),
    .tx_kind    (tx_kind),
    .tx_reg     (tx_reg),
    .tx_pending (tx_pending),
    .eom_pend   (eom_pend)
  );

  mon_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .en        (cfg_enable),
    .bit_en    (bit_en),
    .in_slot   (in_slot),
    .slot_last (slot_last),
    .rx_bit    (rx_bit),
    .rx_data   (rx_data),
    .rx_stb    (rx_stb)
  );

  assert_oe_gated_R1: assert property (@(posedge clk) disable iff (!rst_i_n)
    !cfg_enable |-> !tx_oe && tx_bit && !rx_stb);
endmodule

// File: tb/sim_mon_chan_ctrl.sv
module sim_mon_chan_ctrl;
  logic clk = 1'b0;
  logic rst_n, bit_en, fsync, rx_bit, cfg_enable, cfg_sel, cfg_abort;
  logic eom_set, eom_clr, wr_en;
  logic [7:0] wr_data;
  logic tx_bit, tx_oe, tx_pending, eom_pend, rx_stb;
  logic [1:0] tx_kind;
  logic [7:0] tx_reg, rx_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] f_txb, f_rxv;
  logic [1:0] f_kind;
  int f_oe, f_stb, f_bad, f_stb_at;

  always #2 clk = ~clk;

  mon_chan_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync), .rx_bit(rx_bit),
    .cfg_enable(cfg_enable), .cfg_sel(cfg_sel), .cfg_abort(cfg_abort),
    .eom_set(eom_set), .eom_clr(eom_clr), .wr_en(wr_en), .wr_data(wr_data),
    .tx_bit(tx_bit), .tx_oe(tx_oe), .tx_kind(tx_kind), .tx_reg(tx_reg),
    .tx_pending(tx_pending), .eom_pend(eom_pend), .rx_data(rx_data), .rx_stb(rx_stb)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int slot_start(input logic s);
    return s ? 40 : 8;
  endfunction

  function automatic logic rx_of(input int p, input logic [7:0] b0, input logic [7:0] b1);
    if (p >= 8 && p <= 15)  return b0[7 - (p - 8)];
    if (p >= 40 && p <= 47) return b1[7 - (p - 40)];
    return 1'b1;
  endfunction

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_en = 1'b0; fsync = 1'b0; wr_en = 1'b0; eom_set = 1'b0; eom_clr = 1'b0;
    end
  endtask

  task automatic run_frame(input logic [7:0] b0, input logic [7:0] b1);
    int st;
    st = slot_start(cfg_sel);
    f_txb = 8'hFF; f_kind = 2'd0; f_oe = 0; f_stb = 0; f_bad = 0; f_stb_at = -1; f_rxv = 8'h00;
    for (int b = 0; b < 64; b++) begin
      @(negedge clk);
      bit_en = 1'b1; fsync = (b == 0); rx_bit = rx_of(b - 1, b0, b1);
      @(negedge clk);
      bit_en = 1'b0; fsync = 1'b0;
      if (tx_oe) begin
        f_oe++;
        if (b < st || b > st + 7) f_bad++;
        else begin
          f_txb[7 - (b - st)] = tx_bit;
          f_kind = tx_kind;
        end
      end else if (tx_bit !== 1'b1 || tx_kind !== 2'd0) f_bad++;
      if (rx_stb) begin
        f_stb++; f_rxv = rx_data; f_stb_at = b;
      end
    end
    quiet(2);
  endtask

  task automatic sw_write(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic sw_eom(input bit set, input bit clr);
    @(negedge clk); eom_set = set; eom_clr = clr;
    @(negedge clk); eom_set = 1'b0; eom_clr = 1'b0;
  endtask

  initial begin
    #(4 * 190000);
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    if (!done) begin
      $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; fsync = 1'b0; rx_bit = 1'b1; cfg_enable = 1'b0;
    cfg_sel = 1'b0; cfg_abort = 1'b0; eom_set = 1'b0; eom_clr = 1'b0;
    wr_en = 1'b0; wr_data = 8'h00;
    quiet(4);
    rst_n = 1'b1;
    quiet(4);

    // R2: reset state
    chk(tx_reg == 8'hFF, "R2 reset tx_reg", tx_reg, 8'hFF);
    chk(rx_data == 8'h00, "R2 reset rx_data", rx_data, 0);
    chk(!tx_pending && !eom_pend, "R2 reset flags", {tx_pending, eom_pend}, 0);

    // R1: disabled channel ignores writes and stays off the line
    sw_write(8'h3C);
    chk(tx_reg == 8'hFF && !tx_pending, "R1 write ignored when off", tx_reg, 8'hFF);
    run_frame(8'h5A, 8'hA5);
    chk(f_oe == 0 && f_bad == 0, "R1 no drive when off", f_oe, 0);
    chk(f_stb == 0, "R1 no strobe when off", f_stb, 0);

    // R3 R8 R9: idle octet and reception in each subframe
    cfg_enable = 1'b1;
    for (int s = 0; s < 2; s++) begin
      cfg_sel = s[0];
      quiet(2);
      run_frame(8'h96, 8'h4B);
      chk(f_oe == 8 && f_bad == 0, "R3 slot position", f_oe, 8);
      chk(f_kind == 2'd0 && f_txb == 8'hFF, "R8 idle octet", {f_kind, f_txb}, 8'hFF);
      chk(f_stb == 1 && f_stb_at == slot_start(cfg_sel) + 8, "R9 strobe timing", f_stb_at, slot_start(cfg_sel) + 8);
      chk(f_rxv == (s ? 8'h4B : 8'h96), "R9 rx byte", f_rxv, s ? 8'h4B : 8'h96);
      chk(rx_data == f_rxv, "R9 rx held", rx_data, f_rxv);
    end

    // R4 R3: sweep of data values on both channels
    for (int s = 0; s < 2; s++) begin
      cfg_sel = s[0];
      for (int i = 0; i < 8; i++) begin
        logic [7:0] v, r0, r1;
        v = 8'((i * 37 + 5) ^ (s * 8'h81));
        r0 = 8'(i * 29 + 3);
        r1 = ~r0;
        sw_write(v);
        chk(tx_pending && tx_reg == v, "R4 write pends", tx_reg, v);
        run_frame(r0, r1);
        chk(f_kind == 2'd1 && f_txb == v, "R4 data sent", f_txb, v);
        chk(!tx_pending, "R4 pending cleared", tx_pending, 0);
        chk(f_rxv == (s ? r1 : r0), "R3 rx channel select", f_rxv, s ? r1 : r0);
      end
      run_frame(8'h00, 8'h00);
      chk(f_kind == 2'd0 && f_txb == 8'hFF, "R8 idle after data", f_txb, 8'hFF);
    end

    // R5 R6: end-of-message after drain
    cfg_sel = 1'b0;
    sw_write(8'hC3);
    sw_eom(1, 0);
    chk(eom_pend, "R6 eom set", eom_pend, 1);
    run_frame(8'h11, 8'h22);
    chk(f_kind == 2'd1 && f_txb == 8'hC3, "R5 data before eom", f_txb, 8'hC3);
    chk(eom_pend, "R5 eom held while draining", eom_pend, 1);
    run_frame(8'h11, 8'h22);
    chk(f_kind == 2'd2 && f_txb == 8'hFF, "R5 eom octet", f_kind, 2);
    chk(!eom_pend, "R6 hw clear", eom_pend, 0);
    run_frame(8'h11, 8'h22);
    chk(f_kind == 2'd0, "R6 single eom", f_kind, 0);
    sw_eom(1, 0);
    sw_eom(0, 1);
    chk(!eom_pend, "R6 sw clear", eom_pend, 1'b0);
    run_frame(8'h11, 8'h22);
    chk(f_kind == 2'd0, "R6 no eom after clear", f_kind, 0);

    // R7: abort held for several frames discards pending data
    cfg_sel = 1'b1;
    sw_write(8'h77);
    @(negedge clk); cfg_abort = 1'b1;
    for (int k = 0; k < 3; k++) begin
      run_frame(8'h00, 8'hE1);
      chk(f_kind == 2'd3 && f_txb == 8'hFF, "R7 abort octet", f_kind, 3);
      chk(!tx_pending, "R7 pending discarded", tx_pending, 0);
    end
    @(negedge clk); cfg_abort = 1'b0;
    run_frame(8'h00, 8'hE1);
    chk(f_kind == 2'd0, "R7 idle after abort", f_kind, 0);

    // R2: disabling forces defaults
    sw_write(8'h12);
    @(negedge clk); cfg_enable = 1'b0;
    quiet(2);
    chk(tx_reg == 8'hFF && !tx_pending, "R2 tx default on disable", tx_reg, 8'hFF);
    chk(rx_data == 8'h00, "R2 rx default on disable", rx_data, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule